// File: doc/BRIEF.md
# Request/Reply Receive Buffer with Overflow NACK

This block sits at the receive side of a node in a request/response fabric. Every packet that comes off the network is steered by a one-bit kind field into one of two independent FIFOs: one for requests from other nodes and one for replies to this node's own requests. Because the two paths share no storage, a backed-up request path can never hold a reply behind it. The network input therefore keeps draining even while the node cannot send anything.

Replies are always taken. Request storage is reserved for K outstanding requests from each of the other P-1 nodes. A request that finds that storage full is still taken off the wire. It is turned into a negative acknowledgement addressed to the requesting node, so the request never has to wait for a response it has caused before its slot can be freed.

On the sending side, a gate lets the local node issue a new request only while fewer than K of its requests are waiting for replies. This guarantees that every reply that can arrive already has a reserved reply slot.

Top module: `rr_inbuf`

## Requirements
- R1: After reset both queues are empty, with empty flags high and full flags low. `in_ready` and `iss_ok` are high, and `nack_valid` and `err` are low.
- R2: An accepted packet with `in_kind`=0 is a request and enters the request queue with its source ID and data. With `in_kind`=1 it is a reply and enters the reply queue. Each queue delivers its entries in arrival order.
- R3: The request queue holds exactly K*(NODES-1) entries. `rq_full` rises once that many are held and none have been taken.
- R4: `in_ready` is high whenever `in_kind`=1, even while requests are being refused.
- R5: A request accepted while `rq_full` is high is not queued. One cycle later `nack_valid` rises with `nack_dst` equal to that request's source ID, and both hold until `nack_ready` is seen high.
- R6: `in_ready` is low only when `in_kind`=0, `rq_full` is high, `nack_valid` is high and `nack_ready` is low.
- R7: `iss_ok` is high exactly while fewer than K issued requests are outstanding. A cycle with `iss_req` and `iss_ok` both high adds one. A reply dequeue (`rp_valid` and `rp_ready`) removes one, never going below zero.
- R8: The reply queue holds K entries. A reply accepted while `rp_full` is high is discarded and sets `err`, which stays high until reset.
- R9: The two dequeue ports work independently: replies drain while the request queue sits full with `rq_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Network packet present |
| in_ready | output | 1 | Packet taken this cycle when high |
| in_kind | input | 1 | 0 request, 1 reply |
| in_src | input | SRC_W | Source node ID |
| in_data | input | DATA_W | Packet payload |
| rq_valid | output | 1 | Request queue not empty |
| rq_ready | input | 1 | Pop the head request |
| rq_src | output | SRC_W | Head request source |
| rq_data | output | DATA_W | Head request payload |
| rq_full | output | 1 | Request queue full |
| rq_empty | output | 1 | Request queue empty |
| rp_valid | output | 1 | Reply queue not empty |
| rp_ready | input | 1 | Pop the head reply |
| rp_data | output | DATA_W | Head reply payload |
| rp_full | output | 1 | Reply queue full |
| rp_empty | output | 1 | Reply queue empty |
| iss_req | input | 1 | Local node wants to issue a request |
| iss_ok | output | 1 | Issue permitted |
| nack_valid | output | 1 | NACK pending |
| nack_ready | input | 1 | NACK taken by the sender |
| nack_dst | output | SRC_W | Node the NACK is for |
| err | output | 1 | Sticky reply-overflow flag |

## Verification
The bench first fills the request queue with requests from several sources and checks in-order delivery. It then adds one request beyond capacity, which shows that queueing and NACK generation are told apart. A second overflow request is sent while the NACK is held, and it must be stalled, which separates the stall case from the NACK case. Replies sent during that stall must still be taken. Issue attempts past K check the gate. Reply draining while requests stay parked shows the queues are independent, and an extra reply sent into a full reply queue must raise `err` and be lost.

// File: rtl/rr_inbuf_pkg.sv
`timescale 1ns/1ps
package rr_inbuf_pkg;

   typedef enum logic {
      PK_REQ = 1'b0,
      PK_RPL = 1'b1
   } pkt_kind_e;

   function automatic int req_slots(input int nodes, input int per_node);
      return per_node * (nodes - 1);
   endfunction

endpackage

// File: rtl/rr_fifo.sv
`timescale 1ns/1ps
module rr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rr_fifo: DEPTH must be at least 1");
   end

   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;

   if (POW2) begin : g_wrap_pow2
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nxt = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nxt;
         if (pop_ok)  rp <= rp_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= wdata;
   end

   assign rdata = mem[rp];
   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);

endmodule

// File: rtl/rr_issue_gate.sv
`timescale 1ns/1ps
module rr_issue_gate #(
   parameter int K = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic iss_req,
   input  logic rpl_deq,
   output logic iss_ok
);
   localparam int CW = $clog2(K + 1);

   logic [CW-1:0] outst;
   logic          inc, dec;

   assign iss_ok = (outst < CW'(K));
   assign inc    = iss_req & iss_ok;
   assign dec    = rpl_deq & (outst != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   outst <= outst + 1'b1;
            2'b01:   outst <= outst - 1'b1;
            default: outst <= outst;
         endcase
      end
   end

endmodule

// File: rtl/rr_nack_slot.sv
`timescale 1ns/1ps
module rr_nack_slot #(
   parameter int SRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SRC_W-1:0] load_src,
   input  logic             nack_ready,
   output logic             nack_valid,
   output logic [SRC_W-1:0] nack_dst,
   output logic             can_load
);
   assign can_load = ~nack_valid | nack_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nack_valid <= 1'b0;
         nack_dst   <= '0;
      end else if (load && can_load) begin
         nack_valid <= 1'b1;
         nack_dst   <= load_src;
      end else if (nack_ready) begin
         nack_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/rr_inbuf.sv
`timescale 1ns/1ps
module rr_inbuf #(
   parameter int NODES  = 4,
   parameter int K      = 2,
   parameter int SRC_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_kind,
   input  logic [SRC_W-1:0]  in_src,
   input  logic [DATA_W-1:0] in_data,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic [SRC_W-1:0]  rq_src,
   output logic [DATA_W-1:0] rq_data,
   output logic              rq_full,
   output logic              rq_empty,
   output logic              rp_valid,
   input  logic              rp_ready,
   output logic [DATA_W-1:0] rp_data,
   output logic              rp_full,
   output logic              rp_empty,
   input  logic              iss_req,
   output logic              iss_ok,
   output logic              nack_valid,
   input  logic              nack_ready,
   output logic [SRC_W-1:0]  nack_dst,
   output logic              err
);
   import rr_inbuf_pkg::*;

   localparam int RQ_DEPTH = req_slots(NODES, K);
   localparam int RP_DEPTH = K;
   localparam int RQ_W     = SRC_W + DATA_W;

   if (NODES < 2) begin : g_bad_nodes
      $error("rr_inbuf: NODES must be at least 2");
   end
   if (K < 1) begin : g_bad_k
      $error("rr_inbuf: K must be at least 1");
   end
   if (SRC_W < $clog2(NODES)) begin : g_bad_src
      $error("rr_inbuf: SRC_W too narrow for NODES");
   end

   logic            is_rpl, in_fire;
   logic            rq_push, rp_push, nack_load, can_load;
   logic [RQ_W-1:0] rq_word;

   assign is_rpl    = (in_kind == PK_RPL);
   assign in_ready  = is_rpl | ~rq_full | can_load;
   assign in_fire   = in_valid & in_ready;
   assign rq_push   = in_fire & ~is_rpl & ~rq_full;
   assign nack_load = in_fire & ~is_rpl & rq_full;
   assign rp_push   = in_fire & is_rpl;

   rr_fifo #(.W(RQ_W), .DEPTH(RQ_DEPTH)) u_rq_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rq_push),
      .pop   (rq_ready),
      .wdata ({in_src, in_data}),
      .rdata (rq_word),
      .full  (rq_full),
      .empty (rq_empty)
   );

   assign rq_valid = ~rq_empty;
   assign rq_src   = rq_word[RQ_W-1:DATA_W];
   assign rq_data  = rq_word[DATA_W-1:0];

   rr_fifo #(.W(DATA_W), .DEPTH(RP_DEPTH)) u_rp_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rp_push),
      .pop   (rp_ready),
      .wdata (in_data),
      .rdata (rp_data),
      .full  (rp_full),
      .empty (rp_empty)
   );

   assign rp_valid = ~rp_empty;

   rr_nack_slot #(.SRC_W(SRC_W)) u_nack (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (nack_load),
      .load_src   (in_src),
      .nack_ready (nack_ready),
      .nack_valid (nack_valid),
      .nack_dst   (nack_dst),
      .can_load   (can_load)
   );

   rr_issue_gate #(.K(K)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .iss_req (iss_req),
      .rpl_deq (rp_valid & rp_ready),
      .iss_ok  (iss_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                err <= 1'b0;
      else if (rp_push && rp_full) err <= 1'b1;
   end

endmodule

// File: rtl/rr_inbuf_chk.sv
`timescale 1ns/1ps
module rr_inbuf_chk #(
   parameter int NODES  = 4,
   parameter int K      = 2,
   parameter int SRC_W  = 2,
   parameter int DATA_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_kind,
   input logic             rq_full,
   input logic             rq_empty,
   input logic             rp_valid,
   input logic             rp_ready,
   input logic             rp_full,
   input logic             rp_empty,
   input logic             iss_req,
   input logic             iss_ok,
   input logic             nack_valid,
   input logic             nack_ready,
   input logic [SRC_W-1:0] nack_dst,
   input logic             err
);
   localparam int CW = $clog2(K + 1);

   logic [CW-1:0] out_cnt;
   logic          c_inc, c_dec;

   assign c_inc = iss_req && iss_ok;
   assign c_dec = rp_valid && rp_ready && (out_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)              out_cnt <= '0;
      else if (c_inc && !c_dec) out_cnt <= out_cnt + 1'b1;
      else if (c_dec && !c_inc) out_cnt <= out_cnt - 1'b1;
   end

   // R4
   a_r4_reply_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind) |-> in_ready);

   // R6
   a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_kind && !in_ready) |-> (rq_full && nack_valid && !nack_ready));

   // R5
   a_r5_nack_load: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_kind && rq_full) |=> nack_valid);

   // R5
   a_r5_nack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (nack_valid && !nack_ready) |=> (nack_valid && $stable(nack_dst)));

   // R8
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R3
   a_r3_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rq_full && rq_empty) && !(rp_full && rp_empty));

   // R7
   a_r7_issue_gate: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ok == (out_cnt < CW'(K)));

endmodule

bind rr_inbuf rr_inbuf_chk #(
   .NODES(NODES), .K(K), .SRC_W(SRC_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/rr_inbuf_tb_top.sv
`timescale 1ns/1ps
module rr_inbuf_tb_top;
   localparam int NODES = 4;
   localparam int K     = 2;
   localparam int SW    = 2;
   localparam int DW    = 8;
   localparam int RQD   = K * (NODES - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_kind = 1'b0;
   logic [SW-1:0] in_src = '0;
   logic [DW-1:0] in_data = '0;
   logic rq_ready = 1'b0, rp_ready = 1'b0, nack_ready = 1'b0, iss_req = 1'b0;
   logic in_ready, rq_valid, rq_full, rq_empty, rp_valid, rp_full, rp_empty;
   logic iss_ok, nack_valid, err;
   logic [SW-1:0] rq_src, nack_dst;
   logic [DW-1:0] rq_data, rp_data;

   int n_chk = 0, n_fail = 0, m_out = 0;
   bit done = 0;
   logic [SW+DW-1:0] exp_rq[$];
   logic [DW-1:0]    exp_rp[$];
   logic [SW-1:0]    exp_nk[$];

   always #2.5 clk = ~clk;

   rr_inbuf #(.NODES(NODES), .K(K), .SRC_W(SW), .DATA_W(DW)) dut_i (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops scoreboards as the design hands items out
   always @(negedge clk) begin
      if (rst_n) begin
         if (rq_valid && rq_ready) begin
            if (exp_rq.size() == 0) chk(0, "R2 unexpected request", {rq_src, rq_data}, 0);
            else begin
               chk({rq_src, rq_data} == exp_rq[0], "R2 request order", {rq_src, rq_data}, exp_rq[0]);
               void'(exp_rq.pop_front());
            end
         end
         if (rp_valid && rp_ready) begin
            if (exp_rp.size() == 0) chk(0, "R8 unexpected reply", rp_data, 0);
            else begin
               chk(rp_data == exp_rp[0], "R2 reply order", rp_data, exp_rp[0]);
               void'(exp_rp.pop_front());
            end
            if (m_out > 0) m_out--;
         end
         if (nack_valid && nack_ready) begin
            if (exp_nk.size() == 0) chk(0, "R5 unexpected nack", nack_dst, 0);
            else begin
               chk(nack_dst == exp_nk[0], "R5 nack dest", nack_dst, exp_nk[0]);
               void'(exp_nk.pop_front());
            end
         end
      end
   end

   task automatic send(input logic kind, input logic [SW-1:0] src, input logic [DW-1:0] d,
                       input logic exp_rdy, input string tag);
      @(posedge clk); #1;
      in_valid = 1'b1; in_kind = kind; in_src = src; in_data = d;
      #1;
      chk(in_ready === exp_rdy, tag, in_ready, exp_rdy);
      if (exp_rdy) begin
         if (kind) begin
            if (exp_rp.size() < K) exp_rp.push_back(d);
         end else if (exp_rq.size() < RQD) exp_rq.push_back({src, d});
         else exp_nk.push_back(src);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic issue();
      bit e;
      @(posedge clk); #1;
      iss_req = 1'b1;
      #1;
      e = (m_out < K);
      chk(iss_ok == e, "R7 issue gate", iss_ok, e);
      if (e) m_out++;
      @(posedge clk); #1;
      iss_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rq_empty && rp_empty && !rq_full && !rp_full, "R1 queue flags", {rq_full, rq_empty, rp_full, rp_empty}, 4'b0101);
      chk(in_ready && iss_ok, "R1 ready/issue", {in_ready, iss_ok}, 2'b11);
      chk(!nack_valid && !err && !rq_valid && !rp_valid, "R1 idle outputs", {nack_valid, err, rq_valid, rp_valid}, 0);

      // R2/R3 fill request queue from several sources
      for (int i = 0; i < RQD; i++)
         send(1'b0, SW'(i % 3 + 1), DW'(8'h10 + i), 1'b1, "R2 request accept");
      @(negedge clk);
      chk(rq_full && !rq_empty, "R3 full after K*(P-1)", {rq_full, rq_empty}, 2'b10);

      // R5 overflow request becomes a NACK
      send(1'b0, 2'd3, 8'hA0, 1'b1, "R5 overflow accepted");
      idle(3);
      @(negedge clk);
      chk(nack_valid && nack_dst == 2'd3, "R5 nack held", {nack_valid, nack_dst}, {1'b1, 2'd3});

      // R6 second overflow stalls, R4 reply still taken
      send(1'b0, 2'd1, 8'hA1, 1'b0, "R6 stall on blocked nack");
      send(1'b1, 2'd2, 8'h55, 1'b1, "R4 reply during stall");
      send(1'b1, 2'd2, 8'h66, 1'b1, "R4 reply during stall");

      // R7 issue gate
      issue(); issue(); issue();

      // R9 replies drain while requests stay parked
      rp_ready = 1'b1;
      idle(4);
      rp_ready = 1'b0;
      @(negedge clk);
      chk(rp_empty && rq_full, "R9 reply drain independent", {rp_empty, rq_full}, 2'b11);
      chk(iss_ok == 1'b1 && m_out == 0, "R7 credits returned", iss_ok, 1);
      chk(exp_rp.size() == 0, "R2 replies delivered", exp_rp.size(), 0);

      // R5 release NACK, then overflow with free slot is accepted
      nack_ready = 1'b1;
      idle(2);
      @(negedge clk);
      chk(!nack_valid && exp_nk.size() == 0, "R5 nack released", nack_valid, 0);
      send(1'b0, 2'd2, 8'hBB, 1'b1, "R6 ready while nack drains");
      idle(3);
      chk(exp_nk.size() == 0, "R5 second nack sent", exp_nk.size(), 0);

      // R2 drain requests in order
      rq_ready = 1'b1;
      idle(RQD + 4);
      rq_ready = 1'b0;
      @(negedge clk);
      chk(rq_empty && exp_rq.size() == 0, "R2 requests drained", exp_rq.size(), 0);

      // R8 reply overflow
      send(1'b1, 2'd1, 8'hC1, 1'b1, "R4 reply");
      send(1'b1, 2'd1, 8'hC2, 1'b1, "R4 reply");
      @(negedge clk);
      chk(rp_full && !err, "R8 reply queue holds K", {rp_full, err}, 2'b10);
      send(1'b1, 2'd1, 8'hC3, 1'b1, "R4 reply into full queue");
      @(negedge clk);
      chk(err == 1'b1, "R8 err set", err, 1);
      rp_ready = 1'b1;
      idle(6);
      rp_ready = 1'b0;
      @(negedge clk);
      chk(exp_rp.size() == 0 && rp_empty && err, "R8 extra reply dropped, err sticky", {rp_empty, err}, 2'b11);
      issue();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule